// File: doc/BRIEF.md
# E1 Sa National Bit Multiframe Buffer

This block handles the five national bits (Sa4 to Sa8) that an E1 link carries in timeslot 0 of every frame without the frame alignment word. These are the odd-numbered frames of the 16-frame CRC-4 multiframe. Each Sa position gets its own byte in each direction. A byte is spread over the eight odd frames of one multiframe, one bit per frame, with the most significant bit first.

On the transmit side, the host writes five bytes. Their contents are copied into a shadow bank when frame 0 begins. The block then presents one shadow bit on `tx_sa_bit` whenever the framer strobes an Sa position in an odd frame. On the receive side, the Sa bits from the line are shifted into five assembly registers. When a multiframe finishes cleanly, meaning it started on frame 0 and kept alignment, the assembly registers are copied into five readable bytes and `rx_ready` pulses.

A 4-bit frame counter advances on each frame strobe and is forced to frame 0 by a multiframe alignment pulse. The framer delivers the timeslot-0 bit positions as a strobe plus a 3-bit index. Index 0 is the first bit of the timeslot, so indices 3 to 7 are the positions of Sa4 to Sa8.

Top module: `e1_sa_buffer`

## Requirements
- R1: After synchronous reset: all five host transmit bytes and all five shadow bytes read 8'hFF, all five receive bytes read 8'h00, `rx_ready` is 0, `tx_sa_valid` is 0, and the frame counter is 0.
- R2: A cycle with `frame_stb` high and `mf_align` low advances the frame number by one, modulo 16. A cycle with `mf_align` high makes the next frame number 0, whether or not `frame_stb` is also high. A cycle with neither leaves the frame number unchanged.
- R3: `tx_sa_valid` is 1 exactly when `ts0_stb` is high, the current frame number f is odd and `ts0_pos` is 3 to 7. In that case `tx_sa_bit` equals bit (7 - (f-1)/2) of shadow byte (`ts0_pos` - 3). Byte index 0 to 4 maps to Sa4 to Sa8, so frame 1 carries bit 7 and frame 15 carries bit 0. At all other times `tx_sa_bit` is 0.
- R4: The shadow bank takes the host transmit bytes only in a cycle that starts frame 0. A host write made during a multiframe does not change the bits sent in that multiframe; it first appears in the next one.
- R5: When `ts0_stb` is high, `mf_lock` is 1, the frame number f is odd and `ts0_pos` is 3 to 7, `rx_bit` is shifted in for lane (`ts0_pos` - 3). After a clean multiframe, receive byte k holds the Sa(4+k) bit of frame 1 in bit 7 through to the bit of frame 15 in bit 0.
- R6: The receive bytes are updated, and `rx_ready` is high for exactly one cycle, in the cycle after a frame boundary that leaves frame 15. This happens only if `mf_lock` is 1 in that cycle and the multiframe was entered at frame 0 with `mf_lock` high and kept it high throughout.
- R7: While `mf_lock` is 0, the receive bytes are unchanged and `rx_ready` stays 0. A multiframe during which `mf_lock` was ever 0 is never committed, and neither is one cut short by `mf_align`.
- R8: A write with `wr_en` high and `wr_addr` 0 to 4 sets host transmit byte `wr_addr`; `wr_addr` 5 to 7 changes nothing. `rd_data` is combinational from `rd_addr`: bit 3 set selects the receive bytes, clear selects the host transmit bytes, bits 2:0 pick the byte, and an index of 5 to 7 reads 0.
- R9: Receive bits offered in even frames, or at `ts0_pos` 0 to 2, have no effect on any receive byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse at the start of each frame |
| mf_align | input | 1 | Multiframe alignment pulse; the next frame is frame 0 |
| mf_lock | input | 1 | Multiframe alignment currently held |
| ts0_stb | input | 1 | Timeslot-0 bit strobe |
| ts0_pos | input | 3 | Bit index within timeslot 0 (0 = first bit) |
| rx_bit | input | 1 | Received line bit at the strobed position |
| tx_sa_valid | output | 1 | This block supplies the transmit bit at the strobed position |
| tx_sa_bit | output | 1 | Transmit Sa bit |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host transmit byte index |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Read select: bit 3 = receive bank, bits 2:0 = byte |
| rd_data | output | 8 | Read data |
| rx_ready | output | 1 | One-cycle pulse when new receive bytes are committed |

## Verification
Each failure mode shows at the ports on a fixed schedule:
- A frame counter that is off by one shows on `tx_sa_valid` at the very next timeslot-0 strobe, because the even and odd frames swap.
- A wrong bit selector shows as a corrupted transmit bit in that same strobe cycle.
- A shadow bank that loads at the wrong time shows as a torn transmit byte within the same multiframe.
- Receive-side errors (a mis-steered lane, a missed gate on even frames or on loss of lock, or a commit at the wrong boundary) stay hidden until the next frame-0 boundary. At that point they appear as a wrong `rx_ready` pulse or a wrong byte on `rd_data`, up to one multiframe after the bit that caused them.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

    localparam int SA_LANES     = 5;
    localparam int SA_BITS      = 8;
    localparam int MF_FRAMES    = 16;
    localparam int FRM_W        = $clog2(MF_FRAMES);
    localparam int POS_W        = 3;
    localparam int SA_POS_FIRST = 3;
    localparam int LANE_W       = $clog2(SA_LANES);
    localparam int BITSEL_W     = $clog2(SA_BITS);
    localparam int RD_W         = POS_W + 1;

    typedef logic [SA_BITS-1:0]                sa_byte_t;
    typedef logic [SA_LANES-1:0][SA_BITS-1:0]  sa_bank_t;
    typedef logic [FRM_W-1:0]                  frame_num_t;

    typedef struct packed {
        logic       enter_zero;
        logic       leave_last;
        logic       nfas;
        frame_num_t num;
    } frame_info_t;

    typedef struct packed {
        logic             stb;
        logic [POS_W-1:0] pos;
    } ts0_slot_t;

    function automatic logic is_sa_pos(input logic [POS_W-1:0] pos);
        return int'(pos) >= SA_POS_FIRST;
    endfunction

    function automatic logic [LANE_W-1:0] lane_of(input logic [POS_W-1:0] pos);
        logic [POS_W-1:0] d;
        d = pos - POS_W'(SA_POS_FIRST);
        return d[LANE_W-1:0];
    endfunction

    // odd frame f carries bit (SA_BITS-1) - (f-1)/2, MSB first
    function automatic logic [BITSEL_W-1:0] bit_of_frame(input frame_num_t f);
        return BITSEL_W'(SA_BITS-1) - f[FRM_W-1:1];
    endfunction

endpackage

// File: rtl/e1sa_frame_ctr.sv
module e1sa_frame_ctr
    import e1sa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_stb,
    input  logic        mf_align,
    input  logic        mf_lock,
    output frame_info_t info,
    output logic        mf_clean
);

    frame_num_t num_q;
    frame_num_t num_nx;
    logic       bnd;
    logic       clean_q;

    assign bnd    = frame_stb | mf_align;
    assign num_nx = mf_align ? '0 : num_q + FRM_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q   <= '0;
            clean_q <= 1'b0;
        end else begin
            if (bnd) begin
                num_q <= num_nx;
            end
            if (!mf_lock) begin
                clean_q <= 1'b0;
            end else if (bnd && (num_nx == '0)) begin
                clean_q <= 1'b1;
            end
        end
    end

    assign info.enter_zero = bnd && (num_nx == '0);
    assign info.leave_last = bnd && (num_q == FRM_W'(MF_FRAMES-1));
    assign info.nfas       = num_q[0];
    assign info.num        = num_q;
    assign mf_clean        = clean_q;

endmodule

// File: rtl/e1sa_tx.sv
module e1sa_tx
    import e1sa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_idx,
    input  sa_byte_t         wr_data,
    input  logic             load_shadow,
    input  logic             nfas,
    input  frame_num_t       fnum,
    input  ts0_slot_t        slot,
    output sa_bank_t         host_bank,
    output sa_bank_t         shadow_bank,
    output logic             tx_valid,
    output logic             tx_bit
);

    logic [LANE_W-1:0]   lane;
    logic [BITSEL_W-1:0] bsel;

    for (genvar g = 0; g < SA_LANES; g++) begin : g_lane
        sa_byte_t host_q;
        sa_byte_t shad_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                host_q <= '1;
            end else if (wr_en && (wr_idx == POS_W'(g))) begin
                host_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                shad_q <= '1;
            end else if (load_shadow) begin
                shad_q <= host_q;
            end
        end

        assign host_bank[g]   = host_q;
        assign shadow_bank[g] = shad_q;
    end

    assign lane     = lane_of(slot.pos);
    assign bsel     = bit_of_frame(fnum);
    assign tx_valid = slot.stb && nfas && is_sa_pos(slot.pos);

    always_comb begin
        tx_bit = 1'b0;
        if (tx_valid && (int'(lane) < SA_LANES)) begin
            tx_bit = shadow_bank[lane][bsel];
        end
    end

endmodule

// File: rtl/e1sa_rx.sv
module e1sa_rx
    import e1sa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      nfas,
    input  logic      leave_last,
    input  logic      mf_lock,
    input  logic      mf_clean,
    input  ts0_slot_t slot,
    input  logic      rx_bit,
    output sa_bank_t  rn_bank,
    output logic      rx_ready
);

    logic              capture;
    logic              commit;
    logic [LANE_W-1:0] lane;

    assign lane    = lane_of(slot.pos);
    assign capture = slot.stb && mf_lock && nfas && is_sa_pos(slot.pos);
    assign commit  = leave_last && mf_clean && mf_lock;

    for (genvar g = 0; g < SA_LANES; g++) begin : g_lane
        sa_byte_t sr_q;
        sa_byte_t rn_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sr_q <= '0;
                rn_q <= '0;
            end else begin
                if (commit) begin
                    rn_q <= sr_q;
                end
                if (capture && (lane == LANE_W'(g))) begin
                    sr_q <= {sr_q[SA_BITS-2:0], rx_bit};
                end
            end
        end

        assign rn_bank[g] = rn_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ready <= 1'b0;
        end else begin
            rx_ready <= commit;
        end
    end

endmodule

// File: rtl/e1_sa_buffer.sv
module e1_sa_buffer
    import e1sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              mf_align,
    input  logic              mf_lock,
    input  logic              ts0_stb,
    input  logic [POS_W-1:0]  ts0_pos,
    input  logic              rx_bit,
    output logic              tx_sa_valid,
    output logic              tx_sa_bit,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_addr,
    input  logic [SA_BITS-1:0] wr_data,
    input  logic [RD_W-1:0]   rd_addr,
    output logic [SA_BITS-1:0] rd_data,
    output logic              rx_ready
);

    frame_info_t      info;
    logic             mf_clean;
    ts0_slot_t        slot;
    frame_num_t       fnum;
    sa_bank_t         host_bank;
    sa_bank_t         shadow_bank;
    sa_bank_t         rn_bank;
    logic [POS_W-1:0] rd_idx;
    logic             rd_rx;

    assign slot.stb = ts0_stb;
    assign slot.pos = ts0_pos;
    assign fnum     = info.num;

    e1sa_frame_ctr u_frame (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mf_align  (mf_align),
        .mf_lock   (mf_lock),
        .info      (info),
        .mf_clean  (mf_clean)
    );

    e1sa_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (wr_addr),
        .wr_data     (wr_data),
        .load_shadow (info.enter_zero),
        .nfas        (info.nfas),
        .fnum        (fnum),
        .slot        (slot),
        .host_bank   (host_bank),
        .shadow_bank (shadow_bank),
        .tx_valid    (tx_sa_valid),
        .tx_bit      (tx_sa_bit)
    );

    e1sa_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .nfas       (info.nfas),
        .leave_last (info.leave_last),
        .mf_lock    (mf_lock),
        .mf_clean   (mf_clean),
        .slot       (slot),
        .rx_bit     (rx_bit),
        .rn_bank    (rn_bank),
        .rx_ready   (rx_ready)
    );

    assign rd_idx = rd_addr[POS_W-1:0];
    assign rd_rx  = rd_addr[POS_W];

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < SA_LANES) begin
            rd_data = rd_rx ? rn_bank[rd_idx] : host_bank[rd_idx];
        end
    end

endmodule

// File: rtl/e1sa_checker.sv
module e1sa_checker
    import e1sa_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_stb,
    input logic             mf_align,
    input logic             mf_lock,
    input logic             ts0_stb,
    input logic [POS_W-1:0] ts0_pos,
    input logic             tx_sa_valid,
    input logic             rx_ready,
    input frame_num_t       fnum,
    input sa_bank_t         shadow_bank,
    input sa_bank_t         rn_bank
);

    assert_frame_zero_R2: assert property (@(posedge clk) disable iff (rst)
        mf_align |=> (fnum == '0));

    assert_frame_step_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !mf_align) |=> (fnum == $past(fnum) + FRM_W'(1)));

    assert_frame_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !mf_align) |=> $stable(fnum));

    assert_tx_nfas_only_R3: assert property (@(posedge clk) disable iff (rst)
        tx_sa_valid |-> (fnum[0] && ts0_stb && (int'(ts0_pos) >= SA_POS_FIRST)));

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !((frame_stb || mf_align) && (mf_align || fnum == FRM_W'(MF_FRAMES-1)))
        |=> $stable(shadow_bank));

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    assert_ready_source_R6: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> ($past(fnum) == FRM_W'(MF_FRAMES-1)) && $past(frame_stb || mf_align));

    assert_hold_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        !mf_lock |=> ($stable(rn_bank) && !rx_ready));

endmodule

bind e1_sa_buffer e1sa_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .mf_align    (mf_align),
    .mf_lock     (mf_lock),
    .ts0_stb     (ts0_stb),
    .ts0_pos     (ts0_pos),
    .tx_sa_valid (tx_sa_valid),
    .rx_ready    (rx_ready),
    .fnum        (fnum),
    .shadow_bank (shadow_bank),
    .rn_bank     (rn_bank)
);

// File: tb/e1_sa_buffer_test.sv
module e1_sa_buffer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0, mf_align = 1'b0, mf_lock = 1'b1;
    logic       ts0_stb = 1'b0;
    logic [2:0] ts0_pos = 3'd0;
    logic       rx_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] rd_addr = 4'd0;
    logic       tx_sa_valid, tx_sa_bit, rx_ready;
    logic [7:0] rd_data;

    e1_sa_buffer uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mf_align(mf_align),
        .mf_lock(mf_lock), .ts0_stb(ts0_stb), .ts0_pos(ts0_pos), .rx_bit(rx_bit),
        .tx_sa_valid(tx_sa_valid), .tx_sa_bit(tx_sa_bit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rx_ready(rx_ready)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_tn[5], m_sh[5], m_rn[5], m_sr[5];
    int m_fnum;
    bit m_clean, m_rdy;

    // scenario bookkeeping
    logic [7:0] rxpat[5], bench_tn[5], exp_tx[5], cap[5], rn_exp[5];
    int  lock_lo = -1, lock_hi = -1;
    bit  cur_full = 0, cur_clean = 0, seen_rdy = 0;
    int  pw_frame = -1, pw_n = 0;
    logic [2:0] pw_addr[5];
    logic [7:0] pw_data[5];

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // one clock: check outputs against the model, then advance the model
    task automatic cyc();
        bit ev, bnd, commit;
        int eb, l, nf, ix, erd;
        #1;
        ev = ts0_stb && (m_fnum % 2 == 1) && (int'(ts0_pos) >= 3);
        eb = 0;
        l  = int'(ts0_pos) - 3;
        if (ev) eb = int'(m_sh[l][7 - m_fnum/2]);
        chk("R2 R3 tx_sa_valid", int'(tx_sa_valid), int'(ev));
        chk("R3 tx_sa_bit", int'(tx_sa_bit), eb);
        chk("R6 rx_ready", int'(rx_ready), int'(m_rdy));
        ix  = int'(rd_addr[2:0]);
        erd = 0;
        if (ix < 5) erd = rd_addr[3] ? int'(m_rn[ix]) : int'(m_tn[ix]);
        chk("R8 rd_data", int'(rd_data), erd);
        if (ev) cap[l][7 - m_fnum/2] = tx_sa_bit;
        bnd    = frame_stb || mf_align;
        nf     = mf_align ? 0 : (m_fnum + 1) % 16;
        commit = bnd && (m_fnum == 15) && m_clean && mf_lock;
        if (commit) for (int k = 0; k < 5; k++) m_rn[k] = m_sr[k];
        m_rdy = commit;
        if (ts0_stb && mf_lock && (m_fnum % 2 == 1) && int'(ts0_pos) >= 3)
            m_sr[l] = {m_sr[l][6:0], rx_bit};
        if (bnd && nf == 0) for (int k = 0; k < 5; k++) m_sh[k] = m_tn[k];
        if (wr_en && int'(wr_addr) < 5) m_tn[wr_addr] = wr_data;
        if (!mf_lock) m_clean = 0;
        else if (bnd && nf == 0) m_clean = 1;
        if (bnd) m_fnum = nf;
        @(negedge clk);
    endtask

    task automatic host_wr(input int a, input int d);
        wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
        cyc();
        wr_en = 0;
        if (a < 5) bench_tn[a] = d[7:0];
    endtask

    task automatic do_frame(input bit align, input int f);
        mf_lock = !(f >= lock_lo && f <= lock_hi);
        frame_stb = 1; mf_align = align;
        cyc();
        frame_stb = 0; mf_align = 0;
        seen_rdy = rx_ready;
        for (int p = 0; p < 8; p++) begin
            ts0_stb = 1; ts0_pos = p[2:0];
            if (f % 2 == 1 && p >= 3) rx_bit = rxpat[p-3][7 - f/2];
            else rx_bit = 1'($urandom_range(0, 1));
            cyc();
        end
        ts0_stb = 0; rx_bit = 0;
        if (f == pw_frame) begin
            for (int i = 0; i < pw_n; i++) host_wr(int'(pw_addr[i]), int'(pw_data[i]));
            pw_frame = -1;
        end
        cyc();
        if (!mf_lock) cur_clean = 0;
    endtask

    task automatic mf_pass(input bit align, input int nfr, input logic [39:0] newpat);
        logic [7:0] prev[5];
        bit pf, pc, ec;
        pf = cur_full; pc = cur_clean;
        for (int k = 0; k < 5; k++) begin
            prev[k]   = rxpat[k];
            rxpat[k]  = newpat[k*8 +: 8];
            exp_tx[k] = bench_tn[k];
            cap[k]    = 8'h00;
        end
        for (int f = 0; f < nfr; f++) begin
            do_frame(f == 0 && align, f);
            if (f == 0) begin
                ec = pf && pc && mf_lock;
                cur_clean = mf_lock;
                chk("R6 R7 ready after frame 15", int'(seen_rdy), int'(ec));
                if (ec) for (int k = 0; k < 5; k++) rn_exp[k] = prev[k];
                for (int k = 0; k < 5; k++) begin
                    rd_addr = 4'(8 + k);
                    #1;
                    chk("R5 R7 R9 receive byte", int'(rd_data), int'(rn_exp[k]));
                    cyc();
                end
            end
        end
        cur_full = (nfr == 16);
        if (cur_full)
            for (int k = 0; k < 5; k++)
                chk("R2 R3 R4 transmitted byte", int'(cap[k]), int'(exp_tx[k]));
    endtask

    task automatic check_bank(input string what);
        for (int a = 0; a < 16; a++) begin
            int ix, e;
            rd_addr = a[3:0];
            #1;
            ix = a % 8;
            e  = 0;
            if (ix < 5) e = (a >= 8) ? int'(rn_exp[ix]) : int'(bench_tn[ix]);
            chk(what, int'(rd_data), e);
            cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 5; k++) begin
            m_tn[k] = 8'hFF; m_sh[k] = 8'hFF; m_rn[k] = 8'h00; m_sr[k] = 8'h00;
            bench_tn[k] = 8'hFF; rn_exp[k] = 8'h00; rxpat[k] = 8'h00;
        end
        m_fnum = 0; m_clean = 0; m_rdy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 rx_ready after reset", int'(rx_ready), 0);
        chk("R1 tx_sa_valid after reset", int'(tx_sa_valid), 0);
        check_bank("R1 reset bank value");

        // R8: legal and ignored writes
        host_wr(0, 8'hA5); host_wr(1, 8'h3C); host_wr(2, 8'h0F);
        host_wr(3, 8'hE1); host_wr(4, 8'h96);
        host_wr(5, 8'h11); host_wr(6, 8'h22); host_wr(7, 8'h33);
        check_bank("R8 register port");

        // first aligned multiframe, no commit yet
        mf_pass(1, 16, 40'h5A_C3_81_7E_19);
        // mid-multiframe host writes must not tear this multiframe (R4)
        pw_frame = 5; pw_n = 5;
        pw_addr[0] = 3'd0; pw_data[0] = 8'h12; pw_addr[1] = 3'd1; pw_data[1] = 8'h34;
        pw_addr[2] = 3'd2; pw_data[2] = 8'h56; pw_addr[3] = 3'd3; pw_data[3] = 8'h78;
        pw_addr[4] = 3'd4; pw_data[4] = 8'h9A;
        mf_pass(0, 16, 40'hF0_0F_AA_55_C6);
        mf_pass(0, 16, 40'h24_DB_6E_91_3B);
        // lock lost in frames 4..6 (R7)
        lock_lo = 4; lock_hi = 6;
        mf_pass(0, 16, 40'h77_88_99_EE_01);
        lock_lo = -1; lock_hi = -1;
        mf_pass(0, 16, 40'hBD_42_E7_18_6C);
        // alignment pulse mid-multiframe restarts numbering (R2, R7)
        mf_pass(0, 7, 40'h13_57_9B_DF_02);
        host_wr(2, 8'hC9);
        mf_pass(1, 16, 40'hFE_DC_BA_98_76);
        mf_pass(0, 16, 40'h01_23_45_67_89);
        mf_pass(0, 1, 40'h00_00_00_00_00);
        check_bank("R5 R8 final bank");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule